// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits beside a processor core's execute stage. Each idle cycle it looks at three request sources: a held exception with its number, a fast interrupt line, and a normal interrupt carrying a priority level and an 8-bit vector index. It compares them against the current status word and decides whether one of them is taken. When a request is taken, the block latches everything it needs and runs the entry sequence. It picks the stack, saves the status word and return address, obtains the handler address and produces the edited status word. It finishes with a one-cycle acknowledge pulse in which every result is valid together.

Fast entry touches no memory. The old PC and status word go to backup outputs and the handler address comes from a dedicated register. Normal interrupts and exceptions push two words onto the interrupt stack and then read the handler address from a table, over a single 32-bit request/ready memory port. Exceptions below 0x100 use a fixed table at the top of the address space. Software traps (0x100 and above) use the relocatable table. The block also keeps the core's wait/sleep flag, and any entry clears it.

Top module: `irq_entry_seq`

## Requirements
- R1: A normal request is taken only when status bit 16 (interrupt enable) is 1 and the IPL field (status bits 27:24) is strictly less than `nrm_lvl`; otherwise no acknowledge appears and `busy` stays 0.
- R2: Exceptions are taken regardless of enable and IPL. A fast request is taken when enable is 1 and IPL is below 15. When several are taken in one cycle, exception wins over fast and fast wins over normal.
- R3: With status bit 17 (user stack) set, `usp_new` equals `r0_cur` and the working interrupt stack pointer is `isp_cur`. Otherwise `usp_new` equals `usp_cur` and the working pointer is `r0_cur`. `r0_new` always equals `isp_new`.
- R4: A normal entry writes the status word to working pointer minus 4, then writes `pc_cur` to working pointer minus 8, then reads the handler address from `vbr + 4*nrm_num`. It ends with `isp_new` = working pointer minus 8 and IPL set to `nrm_lvl`.
- R5: An exception pushes exactly as in R4. Its read address is `0xFFFFFFC0 + 4*num` when num < 0x100 and `vbr + 4*(num & 0xFF)` otherwise, and IPL is left unchanged.
- R6: A fast entry makes no memory request. `bk_wr` pulses with `bpc_out = pc_cur` and `bpsw_out` = the old status word, `pc_new = fvec`, IPL becomes 15 and `isp_new` equals the working pointer.
- R7: In `psw_new`, bits 16, 17 and 20 (mode) are 0, bits 27:24 follow R4 to R6, and every other bit equals the old status word.
- R8: A `sleep_set` pulse sets `sleeping`. Accepting any entry clears it, and acceptance wins when both occur in the same cycle.
- R9: Each push or read holds `mem_req`, `mem_we` and `mem_addr` steady until a cycle with `mem_rdy` high. The read data of that cycle becomes `pc_new`.
- R10: `ack_pulse` lasts exactly one cycle per entry. `ack_kind` is 1 for normal, 2 for fast and 3 for exception. `ack_num` is `nrm_num`, 0 or `exc_num` respectively.
- R11: After reset, `busy`, `ack_pulse`, `mem_req`, `bk_wr` and `sleeping` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_set | input | 1 | Core enters the wait state |
| nrm_req | input | 1 | Normal interrupt pending |
| nrm_lvl | input | 4 | Level of the normal request |
| nrm_num | input | 8 | Vector index of the normal request |
| fast_req | input | 1 | Fast interrupt pending |
| exc_req | input | 1 | Exception pending |
| exc_num | input | 9 | Exception number |
| psw_cur | input | 32 | Current packed status word |
| pc_cur | input | 32 | Return address |
| r0_cur | input | 32 | Current stack register |
| isp_cur | input | 32 | Saved interrupt stack pointer |
| usp_cur | input | 32 | Saved user stack pointer |
| vbr | input | 32 | Relocatable vector table base |
| fvec | input | 32 | Fast interrupt handler address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | Entry sequence in progress |
| sleeping | output | 1 | Wait state flag |
| ack_pulse | output | 1 | Entry committed, all results valid |
| ack_kind | output | 2 | Kind of entry taken |
| ack_num | output | 9 | Number of the entry taken |
| pc_new | output | 32 | Handler address |
| psw_new | output | 32 | Edited status word |
| isp_new | output | 32 | New interrupt stack pointer |
| usp_new | output | 32 | New user stack pointer |
| r0_new | output | 32 | New stack register value |
| bk_wr | output | 1 | Backup registers written (fast entry) |
| bpc_out | output | 32 | Backup PC value |
| bpsw_out | output | 32 | Backup status value |

## Verification
Two of the block's functions can collide in one idle cycle. The first is arbitration between a fast and a normal request that are both acceptable. The second is a `sleep_set` pulse arriving in the cycle an entry is accepted. The bench raises both request lines together with enable on and IPL at 14 or lower, and expects a fast acknowledge with no memory traffic and no second entry. In another cycle it drives `sleep_set` together with an accepted request and expects `sleeping` to read 0 one cycle later. Random runs add these overlaps to memory that stalls at random, and every transfer is compared with a trace predicted from the requirements.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_W     = 9;
    localparam int IDX_W     = NUM_W - 1;
    localparam int LVL_W     = 4;
    localparam int KIND_W    = 2;
    localparam int WORD_B    = XLEN / 8;
    localparam int PAD_W     = XLEN - IDX_W - 2;

    localparam int PSW_I_BIT   = 16;
    localparam int PSW_U_BIT   = 17;
    localparam int PSW_PM_BIT  = 20;
    localparam int PSW_IPL_LSB = 24;

    localparam logic [LVL_W-1:0] IPL_TOP        = '1;
    localparam logic [XLEN-1:0]  FIXED_TBL_BASE = 32'hFFFF_FFC0;

    typedef enum logic [KIND_W-1:0] {
        EK_NONE   = 2'd0,
        EK_NORMAL = 2'd1,
        EK_FAST   = 2'd2,
        EK_EXC    = 2'd3
    } entry_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH_PSW,
        SQ_PUSH_PC,
        SQ_FETCH,
        SQ_COMMIT
    } seq_state_e;

    typedef struct packed {
        entry_kind_e      kind;
        logic [NUM_W-1:0] num;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  psw_old;
        logic [XLEN-1:0]  psw_next;
        logic [XLEN-1:0]  isp;
        logic [XLEN-1:0]  usp;
        logic [XLEN-1:0]  vaddr;
    } entry_ctx_t;

    function automatic logic [LVL_W-1:0] psw_ipl(input logic [XLEN-1:0] w);
        return w[PSW_IPL_LSB +: LVL_W];
    endfunction

    function automatic logic [XLEN-1:0] word_index(input logic [IDX_W-1:0] idx);
        return {{PAD_W{1'b0}}, idx, 2'b00};
    endfunction

    function automatic logic uses_stack(input entry_kind_e k);
        return (k == EK_NORMAL) || (k == EK_EXC);
    endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_seq_pkg::*;
(
    input  logic             nrm_req,
    input  logic [LVL_W-1:0] nrm_lvl,
    input  logic             fast_req,
    input  logic             exc_req,
    input  logic [XLEN-1:0]  psw,
    output entry_kind_e      kind
);
    logic             ien;
    logic [LVL_W-1:0] ipl;
    logic             nrm_ok;
    logic             fast_ok;

    assign ien     = psw[PSW_I_BIT];
    assign ipl     = psw_ipl(psw);
    assign nrm_ok  = nrm_req && ien && (ipl < nrm_lvl);
    assign fast_ok = fast_req && ien && (ipl < IPL_TOP);

    always_comb begin
        if (exc_req)      kind = EK_EXC;
        else if (fast_ok) kind = EK_FAST;
        else if (nrm_ok)  kind = EK_NORMAL;
        else              kind = EK_NONE;
    end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
    import irq_seq_pkg::*;
#(
    parameter logic [XLEN-1:0] FIX_BASE = FIXED_TBL_BASE
)(
    input  entry_kind_e      kind,
    input  logic [IDX_W-1:0] nrm_num,
    input  logic [NUM_W-1:0] exc_num,
    input  logic [XLEN-1:0]  vbr,
    input  logic [XLEN-1:0]  fvec,
    output logic [XLEN-1:0]  vaddr
);
    logic             exc_high;
    logic [XLEN-1:0]  exc_base;

    assign exc_high = exc_num[NUM_W-1];
    assign exc_base = exc_high ? vbr : FIX_BASE;

    always_comb begin
        unique case (kind)
            EK_FAST:   vaddr = fvec;
            EK_NORMAL: vaddr = vbr + word_index(nrm_num);
            EK_EXC:    vaddr = exc_base + word_index(exc_num[IDX_W-1:0]);
            default:   vaddr = '0;
        endcase
    end
endmodule

// File: rtl/irq_psw_edit.sv
module irq_psw_edit
    import irq_seq_pkg::*;
(
    input  entry_kind_e      kind,
    input  logic [LVL_W-1:0] nrm_lvl,
    input  logic [XLEN-1:0]  psw_in,
    output logic [XLEN-1:0]  psw_out
);
    logic [LVL_W-1:0] ipl_next;

    always_comb begin
        unique case (kind)
            EK_FAST:   ipl_next = IPL_TOP;
            EK_NORMAL: ipl_next = nrm_lvl;
            default:   ipl_next = psw_ipl(psw_in);
        endcase
    end

    always_comb begin
        psw_out                          = psw_in;
        psw_out[PSW_I_BIT]               = 1'b0;
        psw_out[PSW_U_BIT]               = 1'b0;
        psw_out[PSW_PM_BIT]              = 1'b0;
        psw_out[PSW_IPL_LSB +: LVL_W]    = ipl_next;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [XLEN-1:0] FIX_BASE = FIXED_TBL_BASE
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_set,
    input  logic              nrm_req,
    input  logic [LVL_W-1:0]  nrm_lvl,
    input  logic [IDX_W-1:0]  nrm_num,
    input  logic              fast_req,
    input  logic              exc_req,
    input  logic [NUM_W-1:0]  exc_num,
    input  logic [XLEN-1:0]   psw_cur,
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [XLEN-1:0]   r0_cur,
    input  logic [XLEN-1:0]   isp_cur,
    input  logic [XLEN-1:0]   usp_cur,
    input  logic [XLEN-1:0]   vbr,
    input  logic [XLEN-1:0]   fvec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              sleeping,
    output logic              ack_pulse,
    output logic [KIND_W-1:0] ack_kind,
    output logic [NUM_W-1:0]  ack_num,
    output logic [XLEN-1:0]   pc_new,
    output logic [XLEN-1:0]   psw_new,
    output logic [XLEN-1:0]   isp_new,
    output logic [XLEN-1:0]   usp_new,
    output logic [XLEN-1:0]   r0_new,
    output logic              bk_wr,
    output logic [XLEN-1:0]   bpc_out,
    output logic [XLEN-1:0]   bpsw_out
);
    localparam logic [XLEN-1:0] ONE_SLOT = XLEN'(WORD_B);
    localparam logic [XLEN-1:0] TWO_SLOT = XLEN'(2 * WORD_B);

    seq_state_e       state_q;
    entry_ctx_t       ctx_q;
    logic [XLEN-1:0]  pc_q;
    logic             sleep_q;

    entry_kind_e      take_kind;
    logic [XLEN-1:0]  take_vaddr;
    logic [XLEN-1:0]  take_psw;
    logic             user_stack;
    logic [XLEN-1:0]  work_isp;
    logic [XLEN-1:0]  kept_usp;
    logic             accept;
    logic             xfer_done;
    logic [NUM_W-1:0] take_num;

    irq_accept u_accept (
        .nrm_req  (nrm_req),
        .nrm_lvl  (nrm_lvl),
        .fast_req (fast_req),
        .exc_req  (exc_req),
        .psw      (psw_cur),
        .kind     (take_kind)
    );

    irq_vec_addr #(.FIX_BASE(FIX_BASE)) u_vaddr (
        .kind    (take_kind),
        .nrm_num (nrm_num),
        .exc_num (exc_num),
        .vbr     (vbr),
        .fvec    (fvec),
        .vaddr   (take_vaddr)
    );

    irq_psw_edit u_psw (
        .kind    (take_kind),
        .nrm_lvl (nrm_lvl),
        .psw_in  (psw_cur),
        .psw_out (take_psw)
    );

    // Stack selection: R0 is the live pointer of whichever stack is active.
    assign user_stack = psw_cur[PSW_U_BIT];
    assign work_isp   = user_stack ? isp_cur : r0_cur;
    assign kept_usp   = user_stack ? r0_cur  : usp_cur;
    assign accept     = (state_q == SQ_IDLE) && (take_kind != EK_NONE);
    assign xfer_done  = mem_req && mem_rdy;

    always_comb begin
        unique case (take_kind)
            EK_NORMAL: take_num = {1'b0, nrm_num};
            EK_EXC:    take_num = exc_num;
            default:   take_num = '0;
        endcase
    end

    // Sequencer state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        state_q <= (take_kind == EK_FAST) ? SQ_COMMIT : SQ_PUSH_PSW;
                    end
                end
                SQ_PUSH_PSW: if (xfer_done) state_q <= SQ_PUSH_PC;
                SQ_PUSH_PC:  if (xfer_done) state_q <= SQ_FETCH;
                SQ_FETCH:    if (xfer_done) state_q <= SQ_COMMIT;
                SQ_COMMIT:   state_q <= SQ_IDLE;
                default:     state_q <= SQ_IDLE;
            endcase
        end
    end

    // Entry context captured at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            pc_q  <= '0;
        end else if (accept) begin
            ctx_q.kind     <= take_kind;
            ctx_q.num      <= take_num;
            ctx_q.pc       <= pc_cur;
            ctx_q.psw_old  <= psw_cur;
            ctx_q.psw_next <= take_psw;
            ctx_q.isp      <= work_isp;
            ctx_q.usp      <= kept_usp;
            ctx_q.vaddr    <= take_vaddr;
            pc_q           <= take_vaddr;
        end else if (state_q == SQ_FETCH && xfer_done) begin
            pc_q <= mem_rdata;
        end
    end

    // Wait-state flag: acceptance dominates a simultaneous sleep request
    always_ff @(posedge clk) begin
        if (rst)            sleep_q <= 1'b0;
        else if (accept)    sleep_q <= 1'b0;
        else if (sleep_set) sleep_q <= 1'b1;
    end

    // Memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            SQ_PUSH_PSW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.isp - ONE_SLOT;
                mem_wdata = ctx_q.psw_old;
            end
            SQ_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.isp - TWO_SLOT;
                mem_wdata = ctx_q.pc;
            end
            SQ_FETCH: begin
                mem_req   = 1'b1;
                mem_addr  = ctx_q.vaddr;
            end
            default: ;
        endcase
    end

    // Commit outputs
    assign busy      = (state_q != SQ_IDLE);
    assign sleeping  = sleep_q;
    assign ack_pulse = (state_q == SQ_COMMIT);
    assign ack_kind  = ack_pulse ? ctx_q.kind : EK_NONE;
    assign ack_num   = ack_pulse ? ctx_q.num : '0;
    assign pc_new    = pc_q;
    assign psw_new   = ctx_q.psw_next;
    assign isp_new   = uses_stack(ctx_q.kind) ? (ctx_q.isp - TWO_SLOT) : ctx_q.isp;
    assign usp_new   = ctx_q.usp;
    assign r0_new    = isp_new;
    assign bk_wr     = ack_pulse && (ctx_q.kind == EK_FAST);
    assign bpc_out   = ctx_q.pc;
    assign bpsw_out  = ctx_q.psw_old;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
    import irq_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ack_pulse,
    input logic             bk_wr,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_rdy,
    input logic             mem_we,
    input logic [XLEN-1:0]  mem_addr,
    input logic [XLEN-1:0]  psw_new,
    input logic [XLEN-1:0]  isp_new,
    input logic [XLEN-1:0]  r0_new
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |=> !ack_pulse); // R10

    AST_FAST_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        bk_wr |-> (!mem_req && !$past(mem_req))); // R6

    AST_FAST_IPL_TOP: assert property (@(posedge clk) disable iff (rst)
        bk_wr |-> (psw_ipl(psw_new) == IPL_TOP)); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

    AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |-> (!psw_new[PSW_I_BIT] && !psw_new[PSW_U_BIT] && !psw_new[PSW_PM_BIT])); // R7

    AST_R0_FOLLOWS_ISP: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |-> (r0_new == isp_new)); // R3

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R1
endmodule

bind irq_entry_seq irq_seq_chk u_chk (.*);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        sleep_set, nrm_req, fast_req, exc_req;
    logic [3:0]  nrm_lvl;
    logic [7:0]  nrm_num;
    logic [8:0]  exc_num;
    logic [31:0] psw_cur, pc_cur, r0_cur, isp_cur, usp_cur, vbr, fvec;
    logic        mem_req, mem_we, mem_rdy;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, sleeping, ack_pulse, bk_wr;
    logic [1:0]  ack_kind;
    logic [8:0]  ack_num;
    logic [31:0] pc_new, psw_new, isp_new, usp_new, r0_new, bpc_out, bpsw_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned rdy_pct = 60;
    int unsigned seed_v = 32'd7331;
    logic        finished = 1'b0;

    int unsigned tr_n;
    logic [31:0] tr_addr [0:3];
    logic [31:0] tr_data [0:3];
    logic        tr_we   [0:3];

    always #2 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .sleep_set(sleep_set),
        .nrm_req(nrm_req), .nrm_lvl(nrm_lvl), .nrm_num(nrm_num),
        .fast_req(fast_req), .exc_req(exc_req), .exc_num(exc_num),
        .psw_cur(psw_cur), .pc_cur(pc_cur), .r0_cur(r0_cur),
        .isp_cur(isp_cur), .usp_cur(usp_cur), .vbr(vbr), .fvec(fvec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .busy(busy), .sleeping(sleeping), .ack_pulse(ack_pulse),
        .ack_kind(ack_kind), .ack_num(ack_num), .pc_new(pc_new),
        .psw_new(psw_new), .isp_new(isp_new), .usp_new(usp_new),
        .r0_new(r0_new), .bk_wr(bk_wr), .bpc_out(bpc_out), .bpsw_out(bpsw_out)
    );

    function automatic logic [31:0] table_word(input logic [31:0] a);
        return (a ^ 32'h5A3C_0000) + 32'd17;
    endfunction

    // Memory responder: decides ready away from the clock edge and logs transfers
    initial begin
        mem_rdy = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && (($urandom % 100) < rdy_pct)) begin
                if (tr_n < 4) begin
                    tr_addr[tr_n] = mem_addr;
                    tr_data[tr_n] = mem_wdata;
                    tr_we[tr_n]   = mem_we;
                    tr_n++;
                end
                mem_rdata = table_word(mem_addr);
                mem_rdy   = 1'b1;
            end else begin
                mem_rdy   = 1'b0;
                mem_rdata = 32'hDEAD_0000;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drop_reqs();
        nrm_req = 1'b0; fast_req = 1'b0; exc_req = 1'b0; sleep_set = 1'b0;
    endtask

    // Drives nothing new: uses the current inputs, predicts and checks one entry
    task automatic run_entry();
        logic        ien, usr;
        logic [3:0]  ipl;
        logic [1:0]  ek;
        logic [8:0]  en;
        logic [31:0] w, va, pexp, ispx, pcx;
        bit          seen;
        ien = psw_cur[16]; usr = psw_cur[17]; ipl = psw_cur[27:24];
        if (exc_req)                               begin ek = 2'd3; en = exc_num; end
        else if (fast_req && ien && ipl < 4'd15)   begin ek = 2'd2; en = 9'd0; end
        else if (nrm_req && ien && ipl < nrm_lvl)  begin ek = 2'd1; en = {1'b0, nrm_num}; end
        else                                       begin ek = 2'd0; en = 9'd0; end
        w = usr ? isp_cur : r0_cur;
        if (ek == 2'd1)      va = vbr + {22'd0, nrm_num, 2'b00};
        else if (exc_num[8]) va = vbr + {22'd0, exc_num[7:0], 2'b00};
        else                 va = 32'hFFFF_FFC0 + {22'd0, exc_num[7:0], 2'b00};
        pexp = psw_cur;
        pexp[16] = 1'b0; pexp[17] = 1'b0; pexp[20] = 1'b0;
        if (ek == 2'd2) pexp[27:24] = 4'd15;
        if (ek == 2'd1) pexp[27:24] = nrm_lvl;
        ispx = (ek == 2'd2) ? w : w - 32'd8;
        pcx  = (ek == 2'd2) ? fvec : table_word(va);
        tr_n = 0;
        seen = 0;
        if (ek == 2'd0) begin
            repeat (4) begin
                @(negedge clk);
                if (ack_pulse || busy) seen = 1;
            end
            chk("R1", "no entry when not acceptable", {31'd0, seen}, 32'd0);
            drop_reqs();
            return;
        end
        for (int k = 0; k < 80 && !seen; k++) begin
            @(negedge clk);
            sleep_set = 1'b0;
            if (k == 0) chk("R8", "sleeping cleared at acceptance", {31'd0, sleeping}, 32'd0);
            if (ack_pulse) seen = 1;
        end
        chk("R10", "ack seen", {31'd0, seen}, 32'd1);
        if (!seen) begin drop_reqs(); return; end
        chk("R2", "ack_kind", {30'd0, ack_kind}, {30'd0, ek});
        chk("R10", "ack_num", {23'd0, ack_num}, {23'd0, en});
        chk("R7", "psw_new", psw_new, pexp);
        chk("R3", "usp_new", usp_new, usr ? r0_cur : usp_cur);
        chk("R3", "r0_new", r0_new, ispx);
        chk(ek == 2'd2 ? "R6" : "R4", "isp_new", isp_new, ispx);
        chk("R9", "pc_new", pc_new, pcx);
        chk("R6", "bk_wr", {31'd0, bk_wr}, {31'd0, ek == 2'd2});
        if (ek == 2'd2) begin
            chk("R6", "memory transfers", tr_n, 0);
            chk("R6", "bpc_out", bpc_out, pc_cur);
            chk("R6", "bpsw_out", bpsw_out, psw_cur);
        end else begin
            chk("R4", "memory transfers", tr_n, 3);
            chk("R4", "push1 addr", tr_addr[0], w - 32'd4);
            chk("R4", "push1 data", tr_data[0], psw_cur);
            chk("R4", "push1 we", {31'd0, tr_we[0]}, 32'd1);
            chk("R4", "push2 addr", tr_addr[1], w - 32'd8);
            chk("R4", "push2 data", tr_data[1], pc_cur);
            chk("R4", "push2 we", {31'd0, tr_we[1]}, 32'd1);
            chk(ek == 2'd3 ? "R5" : "R4", "fetch addr", tr_addr[2], va);
            chk("R5", "fetch we", {31'd0, tr_we[2]}, 32'd0);
        end
        drop_reqs();
        @(negedge clk);
        chk("R10", "ack one cycle only", {31'd0, ack_pulse}, 32'd0);
    endtask

    function automatic logic [31:0] mk_psw(input logic i, input logic u, input logic pm, input logic [3:0] ipl);
        logic [31:0] p;
        p = $urandom;
        p[16] = i; p[17] = u; p[20] = pm; p[27:24] = ipl;
        return p;
    endfunction

    task automatic set_ctx();
        pc_cur = $urandom; r0_cur = $urandom; isp_cur = $urandom;
        usp_cur = $urandom; vbr = $urandom; fvec = $urandom;
        nrm_num = 8'($urandom); exc_num = 9'($urandom);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(seed_v));
        rst = 1'b1;
        drop_reqs();
        nrm_lvl = '0; set_ctx(); psw_cur = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy", {31'd0, busy}, 32'd0);
        chk("R11", "ack_pulse", {31'd0, ack_pulse}, 32'd0);
        chk("R11", "mem_req", {31'd0, mem_req}, 32'd0);
        chk("R11", "bk_wr", {31'd0, bk_wr}, 32'd0);
        chk("R11", "sleeping", {31'd0, sleeping}, 32'd0);

        // R8: sleep pulse sets the flag
        sleep_set = 1'b1; @(negedge clk); sleep_set = 1'b0;
        @(negedge clk);
        chk("R8", "sleeping after pulse", {31'd0, sleeping}, 32'd1);

        // R1 normal accepted; sleep pulse collides with acceptance (R8)
        set_ctx(); psw_cur = mk_psw(1, 0, 1, 4'd3); nrm_lvl = 4'd5; nrm_num = 8'h40;
        nrm_req = 1'b1; sleep_set = 1'b1;
        run_entry();
        // R1 equal level refused
        set_ctx(); psw_cur = mk_psw(1, 0, 0, 4'd5); nrm_lvl = 4'd5; nrm_req = 1'b1;
        run_entry();
        // R1 interrupts disabled
        set_ctx(); psw_cur = mk_psw(0, 1, 0, 4'd0); nrm_lvl = 4'd9; nrm_req = 1'b1;
        run_entry();
        // R2 fast and normal together, user stack
        set_ctx(); psw_cur = mk_psw(1, 1, 1, 4'd14); nrm_lvl = 4'd15;
        nrm_req = 1'b1; fast_req = 1'b1;
        run_entry();
        // R2 fast refused at IPL 15
        set_ctx(); psw_cur = mk_psw(1, 0, 0, 4'd15); fast_req = 1'b1; nrm_req = 1'b1; nrm_lvl = 4'd15;
        run_entry();
        // R5 exception with interrupts off, fixed table
        set_ctx(); psw_cur = mk_psw(0, 0, 0, 4'd15); exc_num = 9'd30; exc_req = 1'b1; fast_req = 1'b1;
        run_entry();
        // R5 largest trap number and break number
        set_ctx(); psw_cur = mk_psw(1, 1, 0, 4'd2); exc_num = 9'h1FF; exc_req = 1'b1;
        run_entry();
        set_ctx(); psw_cur = mk_psw(1, 0, 0, 4'd2); exc_num = 9'h100; exc_req = 1'b1;
        run_entry();
        // R9 slow memory
        rdy_pct = 15;
        set_ctx(); psw_cur = mk_psw(1, 0, 0, 4'd0); nrm_lvl = 4'd1; nrm_req = 1'b1;
        run_entry();

        // Random mix
        for (int it = 0; it < 220; it++) begin
            int unsigned sel;
            rdy_pct = 20 + ($urandom % 81);
            set_ctx();
            psw_cur = mk_psw(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
            nrm_lvl = 4'($urandom);
            nrm_req = 1'($urandom); fast_req = 1'($urandom);
            exc_req = (($urandom % 4) == 0);
            sel = $urandom % 7;
            case (sel)
                0: exc_num = 9'd20;
                1: exc_num = 9'd21;
                2: exc_num = 9'd23;
                3: exc_num = 9'd25;
                4: exc_num = 9'd30;
                default: exc_num = {1'b1, 8'($urandom)};
            endcase
            sleep_set = 1'($urandom);
            run_entry();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule